// File: doc/BRIEF.md
# Privileged interrupt pending selector

This block decides which local interrupt a hart should take next, if any. Each cycle it takes the pending and enable bit vectors, a delegation mask, the current privilege level and the two global enable bits (machine and supervisor). It then produces a valid flag and the number of the winning interrupt. That number is also the cause code the trap unit records. Interrupt sources, CSR writes and virtualization handling live elsewhere. This block only arbitrates.

Each candidate interrupt is gated according to where it would trap. An interrupt that is not delegated goes to machine level and follows the machine gate. A delegated interrupt goes to supervisor level and follows the supervisor gate. Each gate is open when the hart runs below the target level, or at the target level with that level's global enable set. Among the interrupts that survive, the lowest-numbered one wins.

The three virtual-supervisor interrupt lines are never ordinary candidates. The result is sampled into a register so that the trap unit sees a stable value one cycle later. That register is a two-state machine:
- SEL_NONE: nothing is selected.
- SEL_HELD: a number is held.

On every clock edge the machine takes one of two transitions:
- to SEL_HELD when a candidate exists;
- to SEL_NONE when none exists.

Top module: `irqsel_top`

## Requirements
- R1: A bit can be selected only if it is set in both `irq_pend` and `irq_en` at the sampling edge.
- R2: A non-delegated bit (its `irq_deleg` bit is 0) is gated open when `cur_priv` is below 3 (machine), or when `cur_priv` is 3 and `glb_mie` is 1. Privilege is encoded as U=0, S=1, M=3.
- R3: A delegated bit (its `irq_deleg` bit is 1) is gated open when `cur_priv` is 0, or when `cur_priv` is 1 and `glb_sie` is 1. At any other privilege it is closed.
- R4: When several gated candidates remain, from either group, the lowest-numbered one is reported in `irq_num`.
- R5: When no gated candidate remains, `irq_valid` is 0 and `irq_num` is 0.
- R6: Bits 2, 6 and 10 (the virtual-supervisor software, timer and external lines) are never selected, whatever their pending, enable and delegation values.
- R7: The outputs reflect the inputs sampled at the previous rising clock edge. Changing the inputs does not change the outputs before the next edge.
- R8: While `rst_n` is 0, `irq_valid` is 0 and `irq_num` is 0, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend | input | 16 | Pending interrupt bits |
| irq_en | input | 16 | Per-interrupt enable bits |
| irq_deleg | input | 16 | 1 = interrupt delegated to supervisor |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| glb_mie | input | 1 | Machine global interrupt enable |
| glb_sie | input | 1 | Supervisor global interrupt enable |
| irq_valid | output | 1 | An interrupt is selected |
| irq_num | output | 4 | Selected interrupt number / cause code |

## Verification
Group gating and lowest-number priority act in the same cycle when both the delegated and the non-delegated group hold pending bits. The bench provokes this by placing a low-numbered candidate in a group whose gate is closed and a higher-numbered one in the open group. It expects the higher number, then opens the other gate and expects the lower number. Exhaustive sweeps over privilege and both global enables, plus random vectors, are judged against a bench-side model written from the requirements.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_t;

    typedef enum logic {
        SEL_NONE = 1'b0,
        SEL_HELD = 1'b1
    } sel_state_t;
endpackage

// File: rtl/irqsel_gate.sv
module irqsel_gate
    import irqsel_pkg::*;
#(
    parameter int          N       = 16,
    parameter logic [N-1:0] VS_MASK = 16'h0444
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] en,
    input  logic [N-1:0] deleg,
    input  priv_t        priv,
    input  logic         mie,
    input  logic         sie,
    output logic [N-1:0] cand
);
    logic [N-1:0] raw;
    logic         gate_m;
    logic         gate_s;

    assign raw = pend & en & ~VS_MASK;

    always_comb begin
        gate_m = (priv != PRIV_M) || mie;
        gate_s = (priv == PRIV_U) || ((priv == PRIV_S) && sie);
    end

    assign cand = (raw & ~deleg & {N{gate_m}}) | (raw & deleg & {N{gate_s}});
endmodule

// File: rtl/irqsel_ctz.sv
module irqsel_ctz #(
    parameter int N = 16,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    logic [N:0]   seen;
    logic [N-1:0] first;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign seen[i+1] = seen[i] | vec[i];
        assign first[i]  = vec[i] & ~seen[i];
    end

    assign found = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx = idx | W'(i);
        end
    end
endmodule

// File: rtl/irqsel_top.sv
module irqsel_top
    import irqsel_pkg::*;
#(
    parameter int           N       = 16,
    parameter logic [N-1:0] VS_MASK = 16'h0444,
    localparam int          W       = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_pend,
    input  logic [N-1:0] irq_en,
    input  logic [N-1:0] irq_deleg,
    input  logic [1:0]   cur_priv,
    input  logic         glb_mie,
    input  logic         glb_sie,
    output logic         irq_valid,
    output logic [W-1:0] irq_num
);
    logic [N-1:0] cand;
    logic         found;
    logic [W-1:0] pick;
    sel_state_t   state_q, state_d;
    logic [W-1:0] num_q, num_d;

    irqsel_gate #(.N(N), .VS_MASK(VS_MASK)) u_gate (
        .pend  (irq_pend),
        .en    (irq_en),
        .deleg (irq_deleg),
        .priv  (priv_t'(cur_priv)),
        .mie   (glb_mie),
        .sie   (glb_sie),
        .cand  (cand)
    );

    irqsel_ctz #(.N(N)) u_ctz (
        .vec   (cand),
        .found (found),
        .idx   (pick)
    );

    always_comb begin
        state_d = state_q;
        num_d   = '0;
        unique case (state_q)
            SEL_NONE: if (found) state_d = SEL_HELD;
            SEL_HELD: if (!found) state_d = SEL_NONE;
            default:  state_d = SEL_NONE;
        endcase
        if (found) num_d = pick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEL_NONE;
            num_q   <= '0;
        end else begin
            state_q <= state_d;
            num_q   <= num_d;
        end
    end

    always_comb begin
        irq_valid = (state_q == SEL_HELD);
        irq_num   = num_q;
    end
endmodule

// File: rtl/irqsel_chk.sv
module irqsel_chk #(
    parameter int           N       = 16,
    parameter logic [N-1:0] VS_MASK = 16'h0444,
    localparam int          W       = (N > 1) ? $clog2(N) : 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] irq_pend,
    input logic [N-1:0] irq_en,
    input logic [N-1:0] irq_deleg,
    input logic [1:0]   cur_priv,
    input logic         glb_mie,
    input logic         glb_sie,
    input logic         irq_valid,
    input logic [W-1:0] irq_num
);
    logic [N-1:0] pend_d, en_d, deleg_d;
    logic [1:0]   priv_d;
    logic         mie_d, sie_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_d <= '0; en_d <= '0; deleg_d <= '0;
            priv_d <= '0; mie_d <= 1'b0; sie_d <= 1'b0;
        end else begin
            pend_d <= irq_pend; en_d <= irq_en; deleg_d <= irq_deleg;
            priv_d <= cur_priv; mie_d <= glb_mie; sie_d <= glb_sie;
        end
    end

    assert_cand_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (pend_d[irq_num] && en_d[irq_num]));

    assert_mgate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !deleg_d[irq_num]) |-> (priv_d != 2'd3 || mie_d));

    assert_sgate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && deleg_d[irq_num]) |-> (priv_d == 2'd0 || (priv_d == 2'd1 && sie_d)));

    assert_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_d & en_d & ~VS_MASK) == '0) |-> !irq_valid);

    assert_idle_num_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_num == '0));

    assert_vs_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !VS_MASK[irq_num]);
endmodule

bind irqsel_top irqsel_chk #(.N(N), .VS_MASK(VS_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_pend  (irq_pend),
    .irq_en    (irq_en),
    .irq_deleg (irq_deleg),
    .cur_priv  (cur_priv),
    .glb_mie   (glb_mie),
    .glb_sie   (glb_sie),
    .irq_valid (irq_valid),
    .irq_num   (irq_num)
);

// File: tb/irqsel_top_tb.sv
`timescale 1ns/1ps
module irqsel_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_pend = '0, irq_en = '0, irq_deleg = '0;
    logic [1:0]  cur_priv = '0;
    logic        glb_mie = 1'b0, glb_sie = 1'b0;
    logic        irq_valid;
    logic [3:0]  irq_num;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irqsel_top u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en),
        .irq_deleg(irq_deleg), .cur_priv(cur_priv), .glb_mie(glb_mie),
        .glb_sie(glb_sie), .irq_valid(irq_valid), .irq_num(irq_num)
    );

    // Model from the requirements: VS lines 2,6,10 excluded; priority by lowest index.
    function automatic logic [4:0] model(input logic [15:0] p, e, d,
                                         input logic [1:0] pr, input logic m, s);
        logic openm, opens;
        openm = (pr < 2'd3) || (pr == 2'd3 && m);
        opens = (pr == 2'd0) || (pr == 2'd1 && s);
        for (int i = 0; i < 16; i++) begin
            if (i != 2 && i != 6 && i != 10 && p[i] && e[i] &&
                ((d[i] && opens) || (!d[i] && openm)))
                return {1'b1, 4'(i)};
        end
        return 5'd0;
    endfunction

    task automatic check(input logic [4:0] exp, input string req);
        n_vec++;
        if ({irq_valid, irq_num} !== exp) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b num=%0d, expected valid=%0b num=%0d",
                     req, irq_valid, irq_num, exp[4], exp[3:0]);
        end
    endtask

    // Drive at negedge, let one rising edge pass, sample at the next negedge.
    task automatic apply(input logic [15:0] p, e, d, input logic [1:0] pr,
                         input logic m, s, input string req);
        irq_pend = p; irq_en = e; irq_deleg = d; cur_priv = pr;
        glb_mie = m; glb_sie = s;
        @(negedge clk);
        check(model(p, e, d, pr, m, s), req);
    endtask

    task automatic t_reset;
        irq_pend = 16'hFFFF; irq_en = 16'hFFFF; cur_priv = 2'd0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(5'd0, "R8 reset");
        rst_n = 1'b1;
        irq_pend = '0; irq_en = '0;
        @(negedge clk);
    endtask

    task automatic t_mgate;
        apply(16'h0008, 16'h0008, 16'h0, 2'd3, 1'b0, 1'b0, "R2 M mie=0");
        check(5'd0, "R2 M mie=0 blocked");
        apply(16'h0008, 16'h0008, 16'h0, 2'd3, 1'b1, 1'b0, "R2 M mie=1");
        check({1'b1, 4'd3}, "R2 M mie=1 taken");
        apply(16'h0008, 16'h0008, 16'h0, 2'd1, 1'b0, 1'b0, "R2 below M");
        check({1'b1, 4'd3}, "R2 S ignores mie");
    endtask

    task automatic t_sgate;
        apply(16'h0020, 16'h0020, 16'h0020, 2'd1, 1'b1, 1'b0, "R3 S sie=0");
        check(5'd0, "R3 S sie=0 blocked");
        apply(16'h0020, 16'h0020, 16'h0020, 2'd1, 1'b0, 1'b1, "R3 S sie=1");
        check({1'b1, 4'd5}, "R3 S sie=1 taken");
        apply(16'h0020, 16'h0020, 16'h0020, 2'd3, 1'b1, 1'b1, "R3 M closed");
        check(5'd0, "R3 delegated masked in M");
        apply(16'h0020, 16'h0020, 16'h0020, 2'd0, 1'b0, 1'b0, "R3 U open");
        check({1'b1, 4'd5}, "R3 U taken");
    endtask

    task automatic t_lowest;
        apply(16'h0A80, 16'hFFFF, 16'h0, 2'd0, 1'b0, 1'b0, "R4 lowest");
        check({1'b1, 4'd7}, "R4 picks 7");
        apply(16'h0202, 16'hFFFF, 16'h0002, 2'd1, 1'b0, 1'b0, "R4 closed low");
        check({1'b1, 4'd9}, "R4 closed group skipped");
        apply(16'h0202, 16'hFFFF, 16'h0002, 2'd1, 1'b0, 1'b1, "R4 both open");
        check({1'b1, 4'd1}, "R4 picks 1");
        apply(16'h8000, 16'h8000, 16'h0, 2'd0, 1'b0, 1'b0, "R4 top bit");
        check({1'b1, 4'd15}, "R4 picks 15");
    endtask

    task automatic t_none;
        apply(16'hFFFF, 16'h0000, 16'h0, 2'd0, 1'b1, 1'b1, "R5 no enable");
        check(5'd0, "R5 none");
        apply(16'h0000, 16'hFFFF, 16'h0, 2'd0, 1'b1, 1'b1, "R5 no pending");
    endtask

    task automatic t_vs;
        apply(16'h0444, 16'hFFFF, 16'h0, 2'd0, 1'b1, 1'b1, "R6 vs only");
        check(5'd0, "R6 vs ignored");
        apply(16'h0444, 16'hFFFF, 16'h0444, 2'd0, 1'b1, 1'b1, "R6 vs delegated");
        apply(16'h1444, 16'hFFFF, 16'h0, 2'd0, 1'b1, 1'b1, "R6 vs plus 12");
        check({1'b1, 4'd12}, "R6 picks 12");
    endtask

    task automatic t_latency;
        apply(16'h0010, 16'h0010, 16'h0, 2'd0, 1'b0, 1'b0, "R7 first");
        irq_pend = 16'h0001; irq_en = 16'h0001;
        #1;
        check({1'b1, 4'd4}, "R7 holds before edge");
        @(negedge clk);
        check({1'b1, 4'd0}, "R7 updates after edge");
    endtask

    task automatic t_sweep;
        logic [15:0] dl [3] = '{16'h0000, 16'hFFFF, 16'h00AA};
        for (int k = 0; k < 3; k++)
            for (int pr = 0; pr < 4; pr++)
                for (int ms = 0; ms < 4; ms++)
                    apply(16'hFBBB, 16'hFFFF, dl[k], 2'(pr), ms[0], ms[1], "R2 R3 sweep");
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++)
            apply(16'($urandom), 16'($urandom), 16'($urandom), 2'($urandom),
                  1'($urandom), 1'($urandom), "R1 R4 random");
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset;
        t_mgate;
        t_sgate;
        t_lowest;
        t_none;
        t_vs;
        t_latency;
        t_sweep;
        t_random;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule